// File: doc/BRIEF.md
# Four-Channel Memory-to-Memory Transfer Engine

This block moves runs of words from one memory region to another on behalf of a processor. Software programs each of four channels with a source pointer, a destination pointer, a word count and a control word. It then enables the channel. A channel becomes eligible when it is enabled, its count is non-zero and its external request line is high. The engine asks the processor for the shared bus with a request/grant handshake. Once it holds the bus, it copies each word with a read cycle followed by a write cycle on a simple synchronous memory port.

Each channel has a two-bit mode field that sets how the bus is shared. In block mode the bus is kept until the whole run is moved. In interleave mode the bus is handed back after every word. In idle-slot mode a word is started only in a cycle where the processor reports that it is not using the bus. When the last word of a run has been written, the channel sets a sticky finished flag. The interrupt output is the OR of all finished flags. Software clears a flag by writing a one to it.

Top module: `dma_mm_ctrl`

## Requirements
- R1: The register port address is {channel[1:0], index[2:0]}. The indexes are: 0 source pointer, 1 destination pointer, 2 word count, 3 control and 4 status. In the control word, bit 0 is enable and bits 2:1 are the mode (0 block, 1 interleave, 2 idle-slot). In the status word, bit 0 is busy (enable set and count non-zero) and bit 1 is finished. Every field reads back as written, and unused bits read as zero.
- R2: A register write made while `bus_grant` is high has no effect.
- R3: A channel asks for the bus only when enable is 1, its count is non-zero and its `chan_req` bit is high. Once raised, `bus_req` stays high until `bus_grant` is seen.
- R4: Among eligible channels the lowest channel number wins. The choice is made only when bus ownership begins, so a higher-priority request that arrives during a block run waits until that run ends.
- R5: Each word is a read of the source pointer, followed in the next cycle by a write of the returned data to the destination pointer. After each word both pointers advance by one and the count drops by one.
- R6: In block mode `bus_req` stays high from the first word until the count reaches zero.
- R7: In interleave mode `bus_req` drops after every word and is not raised again until `bus_grant` has been seen low.
- R8: In idle-slot mode a word's read is issued only in a cycle where `cpu_bus_idle` is high.
- R9: When the final word of a run is written, enable clears and finished sets. `irq` is high while any finished flag is set. Writing 1 to status bit 1 clears that flag.
- R10: `mem_re` and `mem_we` are never high in a cycle where `bus_grant` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 5 | Register address {channel, index} |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data for `cpu_addr` (combinational) |
| chan_req | input | 4 | Per-channel transfer request lines |
| bus_req | output | 1 | Request for the shared bus |
| bus_grant | input | 1 | Processor has released the bus |
| cpu_bus_idle | input | 1 | Processor is not using the bus this cycle |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after `mem_re` |
| irq | output | 1 | Level interrupt, OR of all finished flags |

## Verification
The assertions assume that the processor keeps `bus_grant` high for as long as `bus_req` stays high once it has granted, and that it grants only in answer to a request. They also assume that memory read data arrives exactly one cycle after the read strobe. The bench meets both assumptions with a grant model that registers `bus_req` and can be held off, and with a memory model of fixed one-cycle read latency. All register writes are made while grant is low, except one deliberate write made during a block run.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int REG_W = 32;

    localparam logic [2:0] RI_SRC  = 3'd0;
    localparam logic [2:0] RI_DST  = 3'd1;
    localparam logic [2:0] RI_CNT  = 3'd2;
    localparam logic [2:0] RI_CTRL = 3'd3;
    localparam logic [2:0] RI_STAT = 3'd4;

    localparam logic [1:0] MODE_BLOCK = 2'd0;
    localparam logic [1:0] MODE_INTLV = 2'd1;
    localparam logic [1:0] MODE_IDLE  = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_RD,
        ST_WR,
        ST_REL
    } fsm_e;

endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_idx,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              step,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              en_o,
    output logic [1:0]        mode_o,
    output logic              done_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic              en;
        logic [1:0]        mode;
        logic              done;
    } chan_t;

    chan_t q, d;
    logic  unused_wdata;

    assign unused_wdata = ^wr_data;

    always_comb begin
        d = q;
        if (step) begin
            d.src = q.src + 1'b1;
            d.dst = q.dst + 1'b1;
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.en   = 1'b0;
                d.done = 1'b1;
            end
        end else if (wr_en) begin
            case (wr_idx)
                RI_SRC:  d.src = wr_data[ADDR_W-1:0];
                RI_DST:  d.dst = wr_data[ADDR_W-1:0];
                RI_CNT:  d.cnt = wr_data[CNT_W-1:0];
                RI_CTRL: begin
                    d.en   = wr_data[0];
                    d.mode = wr_data[2:1];
                end
                RI_STAT: if (wr_data[1]) d.done = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign src_o  = q.src;
    assign dst_o  = q.dst;
    assign cnt_o  = q.cnt;
    assign en_o   = q.en;
    assign mode_o = q.mode;
    assign done_o = q.done;

    // R5: pointers advance and count drops once per moved word
    a_r5_step_update: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (q.src == ADDR_W'($past(q.src) + 1'b1)) &&
                 (q.dst == ADDR_W'($past(q.dst) + 1'b1)) &&
                 (q.cnt == CNT_W'($past(q.cnt) - 1'b1)));

    // R9: the last word finishes the run
    a_r9_finish_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (step && q.cnt == CNT_W'(1)) |=> (q.done && !q.en));
endmodule

// File: rtl/dma_mm_ctrl.sv
module dma_mm_ctrl
    import dma_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_we,
    input  logic [((NCH > 1) ? $clog2(NCH) : 1)+2:0] cpu_addr,
    input  logic [dma_pkg::REG_W-1:0]    cpu_wdata,
    output logic [dma_pkg::REG_W-1:0]    cpu_rdata,
    input  logic [NCH-1:0]               chan_req,
    output logic                         bus_req,
    input  logic                         bus_grant,
    input  logic                         cpu_bus_idle,
    output logic                         mem_re,
    output logic                         mem_we,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [DATA_W-1:0]            mem_wdata,
    input  logic [DATA_W-1:0]            mem_rdata,
    output logic                         irq
);
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        fsm_e          st;
        logic [CW-1:0] cur;
    } ctl_t;

    ctl_t q, d;

    logic [ADDR_W-1:0] src_a  [NCH];
    logic [ADDR_W-1:0] dst_a  [NCH];
    logic [CNT_W-1:0]  cnt_a  [NCH];
    logic [1:0]        mode_a [NCH];
    logic [NCH-1:0]    en_v, done_v, busy_v, pending, wr_en_v, step_v;
    logic              step_any, arb_any;
    logic [CW-1:0]     arb_idx, a_ch;
    logic [2:0]        a_idx;
    logic [1:0]        cur_mode;
    logic              cur_busy, cur_last;

    assign a_ch  = cpu_addr[CW+2:3];
    assign a_idx = cpu_addr[2:0];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign wr_en_v[g] = cpu_we && !bus_grant && (a_ch == CW'(g));
        assign step_v[g]  = step_any && (q.cur == CW'(g));
        assign busy_v[g]  = en_v[g] && (cnt_a[g] != '0);

        dma_chan_regs #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W)
        ) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en_v[g]),
            .wr_idx  (a_idx),
            .wr_data (cpu_wdata),
            .step    (step_v[g]),
            .src_o   (src_a[g]),
            .dst_o   (dst_a[g]),
            .cnt_o   (cnt_a[g]),
            .en_o    (en_v[g]),
            .mode_o  (mode_a[g]),
            .done_o  (done_v[g])
        );
    end

    assign pending = busy_v & chan_req;

    dma_prio_arb #(
        .N  (NCH),
        .IW (CW)
    ) u_arb (
        .req (pending),
        .any (arb_any),
        .idx (arb_idx)
    );

    // register read port
    always_comb begin
        cpu_rdata = '0;
        if (int'(a_ch) < NCH) begin
            case (a_idx)
                RI_SRC:  cpu_rdata = REG_W'(src_a[a_ch]);
                RI_DST:  cpu_rdata = REG_W'(dst_a[a_ch]);
                RI_CNT:  cpu_rdata = REG_W'(cnt_a[a_ch]);
                RI_CTRL: cpu_rdata = REG_W'({mode_a[a_ch], en_v[a_ch]});
                RI_STAT: cpu_rdata = REG_W'({done_v[a_ch], busy_v[a_ch]});
                default: cpu_rdata = '0;
            endcase
        end
    end

    assign cur_mode = mode_a[q.cur];
    assign cur_busy = busy_v[q.cur];
    assign cur_last = (cnt_a[q.cur] == CNT_W'(1));

    // transfer sequencer
    always_comb begin
        d        = q;
        mem_re   = 1'b0;
        mem_we   = 1'b0;
        step_any = 1'b0;
        mem_addr = src_a[q.cur];
        case (q.st)
            ST_IDLE: begin
                if (arb_any) begin
                    d.cur = arb_idx;
                    d.st  = ST_REQ;
                end
            end
            ST_REQ: begin
                if (bus_grant) d.st = cur_busy ? ST_RD : ST_REL;
            end
            ST_RD: begin
                if (bus_grant && (cur_mode != MODE_IDLE || cpu_bus_idle)) begin
                    mem_re = 1'b1;
                    d.st   = ST_WR;
                end
            end
            ST_WR: begin
                mem_addr = dst_a[q.cur];
                if (bus_grant) begin
                    mem_we   = 1'b1;
                    step_any = 1'b1;
                    d.st     = (cur_last || cur_mode == MODE_INTLV) ? ST_REL : ST_RD;
                end
            end
            ST_REL: begin
                if (!bus_grant) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st  <= ST_IDLE;
            q.cur <= '0;
        end else begin
            q <= d;
        end
    end

    assign bus_req   = (q.st == ST_REQ) || (q.st == ST_RD) || (q.st == ST_WR);
    assign mem_wdata = mem_rdata;
    assign irq       = |done_v;

    // R3: an unanswered request is held
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_grant) |=> bus_req);

    // R5: a read is followed by its write in the next cycle
    a_r5_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> mem_we);

    // R6: block mode keeps the bus between words
    a_r6_block_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && cur_mode == MODE_BLOCK && !cur_last) |=> bus_req);

    // R7: interleave mode hands the bus back after one word
    a_r7_intlv_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && cur_mode == MODE_INTLV) |=> !bus_req);

    // R7: no new request before grant has been seen low
    a_r7_wait_grant_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && bus_grant) |=> !bus_req);
endmodule

// File: tb/dma_mm_ctrl_bench.sv
`timescale 1ns/1ps
module dma_mm_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [4:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic [3:0]  chan_req = '0;
    logic        bus_req;
    logic        bus_grant;
    logic        cpu_bus_idle = 1'b1;
    logic        mem_re, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        irq;
    logic        hold_grant = 1'b0;

    int checks = 0;
    int errors = 0;
    int rises  = 0;
    logic req_prev = 1'b0;

    typedef struct {
        logic [15:0] a;
        logic [31:0] d;
    } exp_t;
    exp_t exp_q[$];

    logic [31:0] mem [256];

    always #4 clk = ~clk;

    dma_mm_ctrl u_dma_mm_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_rdata    (cpu_rdata),
        .chan_req     (chan_req),
        .bus_req      (bus_req),
        .bus_grant    (bus_grant),
        .cpu_bus_idle (cpu_bus_idle),
        .mem_re       (mem_re),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .irq          (irq)
    );

    function automatic logic [31:0] pattern(input int a);
        return {16'hC0DE, 8'(a), 8'(a * 3 + 1)};
    endfunction

    // processor side: grant follows request by one cycle unless held off
    always @(posedge clk) begin
        if (!rst_n) bus_grant <= 1'b0;
        else        bus_grant <= bus_req && !hold_grant;
    end

    // memory with one-cycle read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= pattern(i);
            mem_rdata <= '0;
        end else begin
            if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // monitor: scoreboard for writes, R8 and R10 watch, request rise counting
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req && !req_prev) rises++;
            req_prev = bus_req;
            if ((mem_re || mem_we) && !bus_grant)
                check(1'b0, "R10 strobe without grant", 32'(mem_re), 32'(0));
            if (mem_re && !cpu_bus_idle)
                check(1'b0, "R8 read while processor busy", 32'(mem_re), 32'(0));
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected write", 32'(mem_addr), 32'(0));
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(mem_addr == e.a, "R5/R4 write address", 32'(mem_addr), 32'(e.a));
                    check(mem_wdata == e.d, "R5 write data", mem_wdata, e.d);
                end
            end
        end
    end

    task automatic expect_copy(input int src, input int dst, input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.a = 16'(dst + i);
            e.d = pattern(src + i);
            exp_q.push_back(e);
        end
    endtask

    task automatic cpu_write(input int ch, input int idx, input logic [31:0] v);
        do begin
            @(posedge clk); #2;
        end while (bus_grant);
        cpu_we = 1'b1; cpu_addr = {2'(ch), 3'(idx)}; cpu_wdata = v;
        @(posedge clk); #2;
        cpu_we = 1'b0;
    endtask

    task automatic cpu_write_raw(input int ch, input int idx, input logic [31:0] v);
        cpu_we = 1'b1; cpu_addr = {2'(ch), 3'(idx)}; cpu_wdata = v;
        @(posedge clk); #2;
        cpu_we = 1'b0;
    endtask

    task automatic cpu_read(input int ch, input int idx, output logic [31:0] v);
        @(posedge clk); #2;
        cpu_addr = {2'(ch), 3'(idx)};
        @(negedge clk);
        v = cpu_rdata;
    endtask

    task automatic prog(input int ch, input int s, input int dd, input int n, input logic [31:0] ctrl);
        cpu_write(ch, 0, 32'(s));
        cpu_write(ch, 1, 32'(dd));
        cpu_write(ch, 2, 32'(n));
        cpu_write(ch, 3, ctrl);
    endtask

    task automatic wait_done(input string tag);
        int k;
        for (k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !bus_req && !bus_grant) break;
        end
        check(k < 3000, tag, 32'(exp_q.size()), 32'(0));
        repeat (3) @(posedge clk);
    endtask

    task automatic clear_done();
        for (int c = 0; c < 4; c++) cpu_write(c, 4, 32'h2);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(!bus_req && !irq && !mem_re && !mem_we, "R1 reset outputs",
              {28'b0, bus_req, irq, mem_re, mem_we}, 32'h0);
        cpu_read(1, 4, v);
        check(v == 32'h0, "R1 reset status", v, 32'h0);

        // R1 register readback
        cpu_write(3, 0, 32'h0040);
        cpu_read(3, 0, v);
        check(v == 32'h0040, "R1 source readback", v, 32'h0040);
        cpu_write(3, 3, 32'hFFFF_FFFA);
        cpu_read(3, 3, v);
        check(v == 32'h2, "R1 control readback mode only", v, 32'h2);
        cpu_write(3, 3, 32'h0);

        // R3 zero count never asks for the bus
        chan_req = 4'b1101;
        prog(2, 8'h60, 8'hE0, 0, 32'h1);
        repeat (8) @(posedge clk);
        @(negedge clk);
        check(!bus_req, "R3 zero count no request", 32'(bus_req), 32'h0);
        cpu_write(2, 3, 32'h0);

        // R3 request line low holds the channel off; then block run (R6)
        expect_copy(8'h10, 8'h80, 4);
        prog(1, 8'h10, 8'h80, 4, 32'h1);
        repeat (8) @(posedge clk);
        @(negedge clk);
        check(!bus_req, "R3 request line low no request", 32'(bus_req), 32'h0);
        rises = 0;
        @(posedge clk); #2 chan_req = 4'b1111;
        do begin @(posedge clk); #2; end while (!bus_grant);
        cpu_write_raw(3, 0, 32'h0099);  // R2: must be ignored
        wait_done("R6 block run completes");
        check(rises == 1, "R6 single request for block run", 32'(rises), 32'h1);
        check(irq, "R9 irq after finish", 32'(irq), 32'h1);
        cpu_read(1, 4, v);
        check(v == 32'h2, "R9 status finished not busy", v, 32'h2);
        cpu_read(1, 3, v);
        check(v == 32'h0, "R9 enable cleared", v, 32'h0);
        cpu_read(1, 0, v);
        check(v == 32'h14, "R5 source advanced", v, 32'h14);
        cpu_read(1, 2, v);
        check(v == 32'h0, "R5 count reached zero", v, 32'h0);
        cpu_read(3, 0, v);
        check(v == 32'h0040, "R2 write during grant ignored", v, 32'h0040);
        cpu_write(1, 4, 32'h2);
        @(negedge clk);
        check(!irq, "R9 irq cleared by write", 32'(irq), 32'h0);

        // R7 interleave: one request per word
        expect_copy(8'h20, 8'h90, 3);
        rises = 0;
        prog(2, 8'h20, 8'h90, 3, 32'h3);
        wait_done("R7 interleave run completes");
        check(rises == 3, "R7 request per word", 32'(rises), 32'h3);
        clear_done();

        // R8 idle-slot with grant held off (R3, R10)
        cpu_bus_idle = 1'b0;
        hold_grant = 1'b1;
        expect_copy(8'h30, 8'hA0, 2);
        prog(0, 8'h30, 8'hA0, 2, 32'h5);
        repeat (6) @(posedge clk);
        @(negedge clk);
        check(bus_req && !bus_grant, "R3 request held while not granted",
              {30'b0, bus_req, bus_grant}, 32'h2);
        @(posedge clk); #2 hold_grant = 1'b0;
        repeat (8) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 2, "R8 no word while processor busy", 32'(exp_q.size()), 32'h2);
        @(posedge clk); #2 cpu_bus_idle = 1'b1;
        wait_done("R8 idle-slot run completes");
        clear_done();

        // R4 priority among simultaneous requests
        chan_req = 4'b0000;
        prog(2, 8'h40, 8'hB0, 2, 32'h3);
        prog(0, 8'h48, 8'hB8, 2, 32'h3);
        expect_copy(8'h48, 8'hB8, 2);
        expect_copy(8'h40, 8'hB0, 2);
        @(posedge clk); #2 chan_req = 4'b0101;
        wait_done("R4 lower channel first");
        clear_done();

        // R4 no preemption during a block run
        chan_req = 4'b0000;
        prog(3, 8'h50, 8'hC0, 3, 32'h1);
        prog(0, 8'h58, 8'hC8, 1, 32'h3);
        expect_copy(8'h50, 8'hC0, 3);
        expect_copy(8'h58, 8'hC8, 1);
        @(posedge clk); #2 chan_req = 4'b1000;
        do begin @(posedge clk); #2; end while (!bus_grant);
        chan_req = 4'b1001;
        wait_done("R4 block run not preempted");
        check(irq, "R9 irq after two runs", 32'(irq), 32'h1);
        clear_done();
        @(negedge clk);
        check(!irq, "R9 irq cleared after all", 32'(irq), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule